// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is the serial control port of a clock generator. It watches a two-wire bus (a clock line and a bidirectional data line) sampled by a faster system clock. It answers one fixed 7-bit device address and serves a small file of 8-bit control registers. The data line is driven open-drain: the block only ever pulls it low, through an output-enable signal, and otherwise leaves it to the bus pull-up.

A command byte that follows the address picks the access type. With its top bit set, the access is a single indexed byte and the low five bits give the register offset. With the top bit clear, the access is a counted block that always starts at register 0. Block writes carry a byte count from the master. Block reads return a byte count from the slave. The registers come out of reset with fixed values, and the last register is read-only. A few register bits leave the block as control outputs: clock output enable, spread enable, spread amount, test-mode entry and test-mode output select.

Top module: `smbc_slave`

## Requirements
- R1: Only the 7-bit address 1101001 is acknowledged: the address byte D2h (write) and D3h (read). Any other address byte is not acknowledged, and the data line stays released until the next start condition.
- R2: Command byte fields: bit 7 = 1 selects a single-byte access at the offset in bits 4:0, and bit 7 = 0 selects a block access. The command is acknowledged only if bits 6:5 are 00 and, for a block access, bits 4:0 are 00000. Otherwise it is not acknowledged and the block goes idle.
- R3: After reset, registers 0 to 7 read back as 7Ch, 00h, EBh, AFh, 01h, 00h, 13h and 01h.
- R4: A byte write (D2h, command, data, stop) stores the data byte at the offset. Further data bytes in the same transfer are acknowledged and discarded.
- R5: A block write (D2h, command 00h, count, data...) stores data bytes into registers 0, 1, 2 and upward, one per byte, up to the count. Bytes beyond the count are acknowledged and discarded. A stop after any complete byte keeps the writes already made.
- R6: Register 7 is read-only. Writes to it, to any offset of 8 or above, and block data aimed past register 6 are acknowledged and discarded.
- R7: A block read (D2h, 00h, repeated start, D3h) returns 08h, then registers 0 to 7 in ascending order, MSB first. Any byte after register 7 reads 00h. A master not-acknowledge ends the transfer.
- R8: A byte read (D2h, command, repeated start, D3h) returns the register at the command offset. An offset of 8 or above returns 00h.
- R9: Each accepted byte is acknowledged by pulling the data line low for the ninth clock. The data line changes only while the bus clock is low.
- R10: Control outputs follow their register bits: clk_out_en = reg0 bit 2, ssc_en = reg2 bit 2, ssc_down_sel = reg2 bit 7, tmode_en = reg6 bit 6, tmode_sel = reg6 bit 7. After reset these are 1, 0, 1, 0 and 0.
- R11: A start or stop condition in the middle of a byte abandons that byte without writing it. A repeated start keeps the command offset that was already received. A stop releases the data line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| clk_out_en | output | 1 | Clock output enable (0 = high impedance) |
| ssc_en | output | 1 | Spread-spectrum enable (1 = on) |
| ssc_down_sel | output | 1 | Spread amount (0 = -0.35 %, 1 = -0.5 %) |
| tmode_en | output | 1 | Test clock mode entry |
| tmode_sel | output | 1 | Test-mode output (0 = high impedance, 1 = reference divided by N) |

## Verification
The hardest case to reach from the pins is a start or stop condition inside a byte. A well-behaved master never produces one, yet the slave must drop the partial byte while keeping the command already received. The bench drives the two lines at the level of single bits. It sends three data bits after a byte-write command, then raises a repeated start and reads back through the stored offset. It also ends another transfer with a stop after three bits. It then confirms that the target register kept its old value and that the next transfer still works. Separate sweeps cover every 7-bit address and every command byte, and the acknowledge expected for each is computed from the field rules.

// File: rtl/smbc_pkg.sv
package smbc_pkg;
   localparam int REG_W     = 8;
   localparam int NUM_REGS  = 8;
   localparam int OFF_W     = 5;
   localparam logic [6:0] DEV_ADDR = 7'h69;

   // register 7 sits in the top byte, register 0 in the bottom byte
   localparam logic [NUM_REGS*REG_W-1:0] REG_RESET = 64'h01130001AFEB007C;
   localparam logic [NUM_REGS-1:0]       REG_RO    = 8'h80;

   // flat bit positions (register * 8 + bit) of the exported controls
   localparam int NUM_TAPS = 5;
   localparam logic [NUM_TAPS*8-1:0] TAP_POS = {8'd55, 8'd54, 8'd23, 8'd18, 8'd2};

   typedef enum logic [2:0] {
      S_IDLE, S_RXB, S_ACKW, S_ACKD, S_TXB, S_MACK
   } bus_st_t;

   typedef enum logic [1:0] {
      P_ADDR, P_CMD, P_CNT, P_DATA
   } phase_t;
endpackage

// File: rtl/smbc_sync.sv
module smbc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   if (STAGES < 2) begin : g_bad_stages
      $error("smbc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_ff, sda_ff;
   logic              scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_q  <= scl_ff[STAGES-1];
         sda_q  <= sda_ff[STAGES-1];
      end
   end

   assign scl_s     = scl_ff[STAGES-1];
   assign sda_s     = sda_ff[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smbc_regfile.sv
module smbc_regfile #(
   parameter int                     NREG     = 8,
   parameter int                     DW       = 8,
   parameter logic [NREG*DW-1:0]     RST_VAL  = '0,
   parameter logic [NREG-1:0]        RO_MASK  = '0,
   parameter int                     NTAP     = 1,
   parameter logic [NTAP*8-1:0]      TAP_POS  = '0,
   localparam int                    AW       = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [AW-1:0]   waddr,
   input  logic [DW-1:0]   wdata,
   input  logic [AW-1:0]   raddr,
   output logic [DW-1:0]   rdata,
   output logic [NTAP-1:0] taps
);
   if (NREG < 2 || NREG > 64) begin : g_bad_nreg
      $error("smbc_regfile: NREG out of range");
   end

   logic [NREG*DW-1:0] q;

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (RO_MASK[i]) begin : g_ro
         assign q[i*DW +: DW] = RST_VAL[i*DW +: DW];
      end else begin : g_rw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q[i*DW +: DW] <= RST_VAL[i*DW +: DW];
            else if (we && waddr == AW'(i))
               q[i*DW +: DW] <= wdata;
         end
      end
   end

   assign rdata = q[int'(raddr)*DW +: DW];

   for (genvar t = 0; t < NTAP; t++) begin : g_tap
      localparam int POS = int'(TAP_POS[t*8 +: 8]);
      if (POS >= NREG*DW) begin : g_bad_tap
         $error("smbc_regfile: tap position out of range");
      end
      assign taps[t] = q[POS];
   end

   // R6: the sequencer never aims a write at a read-only register
   a_r6_no_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> !RO_MASK[waddr]);
endmodule

// File: rtl/smbc_fsm.sv
module smbc_fsm
   import smbc_pkg::*;
#(
   parameter int              NREG     = 8,
   parameter int              DW       = 8,
   parameter int              OFFW     = 5,
   parameter logic [6:0]      SLV_ADDR = 7'h69,
   parameter logic [NREG-1:0] RO_MASK  = '0,
   localparam int             AW       = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_s,
   input  logic          sda_s,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          start_det,
   input  logic          stop_det,
   output logic          sda_oe,
   output logic          we,
   output logic [AW-1:0] waddr,
   output logic [DW-1:0] wdata,
   output logic [AW-1:0] raddr,
   input  logic [DW-1:0] rdata
);
   localparam int PW = OFFW + 1;
   localparam logic [PW-1:0] PMAX = '1;

   if (DW != 8) begin : g_bad_dw
      $error("smbc_fsm: bus bytes are 8 bits wide");
   end
   if (OFFW > 6 || PW <= AW) begin : g_bad_offw
      $error("smbc_fsm: OFFW does not fit the command byte or the register count");
   end

   bus_st_t       st;
   phase_t        phase;
   logic [3:0]    bitcnt;
   logic [7:0]    sh;
   logic [7:0]    remain;
   logic [PW-1:0] ptr;
   logic          blk, ack_pend, tx_pend, cnt_pend, mack_ok;

   logic [7:0]    rx_byte;
   logic          ptr_hit, writable, cmd_ok;
   logic [7:0]    rd_val;
   logic [PW-1:0] ptr_nx;

   always_comb begin
      rx_byte  = {sh[6:0], sda_s};
      ptr_hit  = ptr < PW'(NREG);
      raddr    = ptr[AW-1:0];
      rd_val   = ptr_hit ? rdata : 8'h00;
      writable = ptr_hit && !RO_MASK[raddr];
      ptr_nx   = (ptr == PMAX) ? ptr : ptr + 1'b1;
      cmd_ok   = (rx_byte[6:OFFW] == '0) &&
                 (rx_byte[7] || rx_byte[OFFW-1:0] == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         phase    <= P_ADDR;
         bitcnt   <= '0;
         sh       <= '0;
         remain   <= '0;
         ptr      <= '0;
         blk      <= 1'b0;
         ack_pend <= 1'b0;
         tx_pend  <= 1'b0;
         cnt_pend <= 1'b0;
         mack_ok  <= 1'b0;
         we       <= 1'b0;
         waddr    <= '0;
         wdata    <= '0;
      end else begin
         we <= 1'b0;
         if (start_det) begin
            st      <= S_RXB;
            bitcnt  <= '0;
            phase   <= P_ADDR;
            tx_pend <= 1'b0;
         end else if (stop_det) begin
            st      <= S_IDLE;
            phase   <= P_ADDR;
            tx_pend <= 1'b0;
         end else begin
            case (st)
               S_RXB: begin
                  if (scl_rise) begin
                     sh     <= rx_byte;
                     bitcnt <= bitcnt + 1'b1;
                     if (bitcnt == 4'd7) begin
                        st       <= S_ACKW;
                        ack_pend <= 1'b0;
                        case (phase)
                           P_ADDR: begin
                              if (rx_byte[7:1] == SLV_ADDR) begin
                                 ack_pend <= 1'b1;
                                 if (rx_byte[0]) begin
                                    tx_pend  <= 1'b1;
                                    cnt_pend <= blk;
                                    phase    <= P_DATA;
                                 end else begin
                                    phase <= P_CMD;
                                 end
                              end
                           end
                           P_CMD: begin
                              if (cmd_ok) begin
                                 ack_pend <= 1'b1;
                                 blk      <= ~rx_byte[7];
                                 ptr      <= rx_byte[7] ? PW'(rx_byte[OFFW-1:0]) : '0;
                                 remain   <= 8'd1;
                                 phase    <= rx_byte[7] ? P_DATA : P_CNT;
                              end
                           end
                           P_CNT: begin
                              ack_pend <= 1'b1;
                              remain   <= rx_byte;
                              phase    <= P_DATA;
                           end
                           default: begin
                              ack_pend <= 1'b1;
                              if (remain != 8'd0) begin
                                 remain <= remain - 8'd1;
                                 ptr    <= ptr_nx;
                                 if (writable) begin
                                    we    <= 1'b1;
                                    waddr <= raddr;
                                    wdata <= rx_byte;
                                 end
                              end
                           end
                        endcase
                     end
                  end
               end
               S_ACKW: begin
                  if (scl_fall)
                     st <= ack_pend ? S_ACKD : S_IDLE;
               end
               S_ACKD: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (tx_pend) begin
                        st <= S_TXB;
                        if (cnt_pend) begin
                           sh       <= 8'(NREG);
                           cnt_pend <= 1'b0;
                        end else begin
                           sh  <= rd_val;
                           ptr <= ptr_nx;
                        end
                     end else begin
                        st <= S_RXB;
                     end
                  end
               end
               S_TXB: begin
                  if (scl_rise) begin
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall) begin
                     if (bitcnt == 4'd8) begin
                        st      <= S_MACK;
                        mack_ok <= 1'b0;
                     end else begin
                        sh <= {sh[6:0], 1'b0};
                     end
                  end
               end
               S_MACK: begin
                  if (scl_rise) begin
                     if (!sda_s) begin
                        mack_ok <= 1'b1;
                        sh      <= rd_val;
                        ptr     <= ptr_nx;
                     end else begin
                        st <= S_IDLE;
                     end
                  end else if (scl_fall && mack_ok) begin
                     st     <= S_TXB;
                     bitcnt <= '0;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe = (st == S_ACKD) || (st == S_TXB && !sh[7]);

   // R9: the slave moves the data line only while the bus clock is low
   a_r9_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);

   // R11: a stop condition leaves the data line released
   a_r11_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);
endmodule

// File: rtl/smbc_slave.sv
module smbc_slave
   import smbc_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe,
   output logic clk_out_en,
   output logic ssc_en,
   output logic ssc_down_sel,
   output logic tmode_en,
   output logic tmode_sel
);
   localparam int AW = $clog2(NUM_REGS);

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic          we;
   logic [AW-1:0] waddr, raddr;
   logic [REG_W-1:0] wdata, rdata;
   logic [NUM_TAPS-1:0] taps;

   smbc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   smbc_fsm #(
      .NREG     (NUM_REGS),
      .DW       (REG_W),
      .OFFW     (OFF_W),
      .SLV_ADDR (DEV_ADDR),
      .RO_MASK  (REG_RO)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .sda_oe    (sda_oe),
      .we        (we),
      .waddr     (waddr),
      .wdata     (wdata),
      .raddr     (raddr),
      .rdata     (rdata)
   );

   smbc_regfile #(
      .NREG    (NUM_REGS),
      .DW      (REG_W),
      .RST_VAL (REG_RESET),
      .RO_MASK (REG_RO),
      .NTAP    (NUM_TAPS),
      .TAP_POS (TAP_POS)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we),
      .waddr (waddr),
      .wdata (wdata),
      .raddr (raddr),
      .rdata (rdata),
      .taps  (taps)
   );

   assign clk_out_en   = taps[0];
   assign ssc_en       = taps[1];
   assign ssc_down_sel = taps[2];
   assign tmode_en     = taps[3];
   assign tmode_sel    = taps[4];

   // R10: a write to register 0 shows up on the clock enable one cycle later
   a_r10_clk_en_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr == '0) |=> (clk_out_en == $past(wdata[2])));
endmodule

// File: tb/smbc_slave_bench.sv
`timescale 1ns/1ps
module smbc_slave_bench;
   localparam int Q = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_bus;
   logic sda_oe, clk_out_en, ssc_en, ssc_down_sel, tmode_en, tmode_sel;

   always #5 clk = ~clk;
   assign sda_bus = sda_m & ~sda_oe;

   smbc_slave u_smbc_slave (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_i        (scl_m),
      .sda_i        (sda_bus),
      .sda_oe       (sda_oe),
      .clk_out_en   (clk_out_en),
      .ssc_en       (ssc_en),
      .ssc_down_sel (ssc_down_sel),
      .tmode_en     (tmode_en),
      .tmode_sel    (tmode_sel)
   );

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] exp_reg [8];
   logic [7:0] bw [12];
   logic [7:0] rb [12];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic m_start();
      sda_m = 1'b1; #(Q);
      scl_m = 1'b1; #(Q);
      sda_m = 1'b0; #(Q);
      scl_m = 1'b0; #(Q);
   endtask

   task automatic m_stop();
      sda_m = 1'b0; #(Q);
      scl_m = 1'b1; #(Q);
      sda_m = 1'b1; #(Q);
      #(Q);
   endtask

   task automatic m_bit_out(input logic b);
      sda_m = b; #(Q);
      scl_m = 1'b1; #(2*Q);
      scl_m = 1'b0; #(Q);
   endtask

   task automatic m_bit_in(output logic b);
      sda_m = 1'b1; #(Q);
      scl_m = 1'b1; #(Q);
      b = sda_bus; #(Q);
      scl_m = 1'b0; #(Q);
   endtask

   task automatic m_send(input logic [7:0] b, output logic ack);
      logic a;
      for (int i = 7; i >= 0; i--) m_bit_out(b[i]);
      m_bit_in(a);
      ack = !a;
   endtask

   task automatic m_recv(input logic ack, output logic [7:0] b);
      logic v;
      for (int i = 7; i >= 0; i--) begin
         m_bit_in(v);
         b[i] = v;
      end
      m_bit_out(ack ? 1'b0 : 1'b1);
   endtask

   task automatic wr_byte(input string req, input logic [4:0] off, input logic [7:0] d);
      logic a;
      m_start();
      m_send(8'hD2, a); chk({req, " R9 addr ack"}, a, 1);
      m_send({3'b100, off}, a); chk({req, " R9 cmd ack"}, a, 1);
      m_send(d, a); chk({req, " R9 data ack"}, a, 1);
      m_stop();
      if (off < 7) exp_reg[off] = d;
   endtask

   task automatic rd_byte(input logic [4:0] off, output logic [7:0] d);
      logic a;
      m_start();
      m_send(8'hD2, a);
      m_send({3'b100, off}, a);
      m_start();
      m_send(8'hD3, a); chk("R1 read addr ack", a, 1);
      m_recv(1'b0, d);
      m_stop();
   endtask

   task automatic blk_wr(input logic [7:0] cnt, input int n);
      logic a;
      m_start();
      m_send(8'hD2, a); chk("R5 addr ack", a, 1);
      m_send(8'h00, a); chk("R5 cmd ack", a, 1);
      m_send(cnt, a); chk("R5 count ack", a, 1);
      for (int k = 0; k < n; k++) begin
         m_send(bw[k], a); chk("R5 data ack", a, 1);
         if (k < int'(cnt) && k < 7) exp_reg[k] = bw[k];
      end
      m_stop();
   endtask

   task automatic blk_rd(input int n);
      logic a;
      m_start();
      m_send(8'hD2, a);
      m_send(8'h00, a);
      m_start();
      m_send(8'hD3, a); chk("R7 read addr ack", a, 1);
      for (int k = 0; k < n; k++) m_recv(k != n - 1, rb[k]);
      m_stop();
   endtask

   task automatic check_block(input string req);
      blk_rd(10);
      chk({req, " R7 count"}, rb[0], 8'h08);
      for (int k = 0; k < 8; k++) chk({req, " R7 reg"}, rb[k+1], exp_reg[k]);
      chk({req, " R7 past end"}, rb[9], 8'h00);
      chk({req, " R11 released"}, sda_oe, 0);
   endtask

   initial begin
      #(1800us);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic a;
      logic [7:0] d;
      logic expa;
      exp_reg[0] = 8'h7C; exp_reg[1] = 8'h00; exp_reg[2] = 8'hEB; exp_reg[3] = 8'hAF;
      exp_reg[4] = 8'h01; exp_reg[5] = 8'h00; exp_reg[6] = 8'h13; exp_reg[7] = 8'h01;
      repeat (5) @(posedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #2;
      #(4*Q);

      // R10 and R3: reset state of the control outputs
      chk("R10 clk_out_en reset", clk_out_en, 1);
      chk("R10 ssc_en reset", ssc_en, 0);
      chk("R10 ssc_down_sel reset", ssc_down_sel, 1);
      chk("R10 tmode_en reset", tmode_en, 0);
      chk("R10 tmode_sel reset", tmode_sel, 0);
      chk("R9 released at reset", sda_oe, 0);

      // R3 and R7: defaults through a block read
      check_block("R3 defaults");

      // R1: every 7-bit address with the write bit
      for (int ad = 0; ad < 128; ad++) begin
         m_start();
         m_send({ad[6:0], 1'b0}, a);
         m_stop();
         chk("R1 address sweep", a, ad == 'h69);
      end

      // R2: every command byte
      for (int c = 0; c < 256; c++) begin
         logic [7:0] cb;
         cb = c[7:0];
         m_start();
         m_send(8'hD2, a);
         m_send(cb, a);
         m_stop();
         expa = (cb[6:5] == 2'b00) && (cb[7] || cb[4:0] == 5'd0);
         chk("R2 command sweep", a, expa);
      end

      // R4: byte write with a trailing extra byte
      m_start();
      m_send(8'hD2, a); chk("R4 addr ack", a, 1);
      m_send(8'h81, a); chk("R4 cmd ack", a, 1);
      m_send(8'h5A, a); chk("R4 data ack", a, 1);
      m_send(8'hA5, a); chk("R4 extra ack", a, 1);
      m_stop();
      exp_reg[1] = 8'h5A;
      rd_byte(5'd1, d); chk("R4 written byte", d, 8'h5A);
      rd_byte(5'd2, d); chk("R4 neighbour untouched", d, exp_reg[2]);

      // R10: control bits follow register writes
      wr_byte("R10", 5'd0, 8'h00);
      chk("R10 clk_out_en cleared", clk_out_en, 0);
      wr_byte("R10", 5'd2, 8'h04);
      chk("R10 ssc_en set", ssc_en, 1);
      chk("R10 ssc_down_sel cleared", ssc_down_sel, 0);
      wr_byte("R10", 5'd6, 8'hC0);
      chk("R10 tmode_en set", tmode_en, 1);
      chk("R10 tmode_sel set", tmode_sel, 1);

      // R6 and R8: read-only register and offsets past the file
      wr_byte("R6", 5'd7, 8'hFF);
      rd_byte(5'd7, d); chk("R6 reg7 read-only", d, 8'h01);
      wr_byte("R6", 5'd9, 8'h55);
      rd_byte(5'd9, d); chk("R8 offset past end", d, 8'h00);
      rd_byte(5'd31, d); chk("R8 top offset", d, 8'h00);
      rd_byte(5'd3, d); chk("R8 byte read", d, exp_reg[3]);

      // R5: count shorter than the data
      bw[0] = 8'h11; bw[1] = 8'h22; bw[2] = 8'h33; bw[3] = 8'h44;
      blk_wr(8'd3, 4);
      check_block("R5 short count");

      // R5 and R6: data running past the last writable register
      for (int k = 0; k < 9; k++) bw[k] = 8'((k << 4) + 5);
      blk_wr(8'd9, 9);
      check_block("R6 block past end");

      // R5: master stops early
      bw[0] = 8'hC3; bw[1] = 8'h3C;
      blk_wr(8'd5, 2);
      rd_byte(5'd0, d); chk("R5 early stop reg0", d, 8'hC3);
      rd_byte(5'd1, d); chk("R5 early stop reg1", d, 8'h3C);
      rd_byte(5'd2, d); chk("R5 early stop reg2", d, exp_reg[2]);

      // R11: repeated start inside a data byte keeps the offset
      m_start();
      m_send(8'hD2, a);
      m_send(8'h82, a); chk("R11 cmd ack", a, 1);
      m_bit_out(1'b1); m_bit_out(1'b0); m_bit_out(1'b1);
      m_start();
      m_send(8'hD3, a); chk("R11 read after restart", a, 1);
      m_recv(1'b0, d);
      m_stop();
      chk("R11 partial byte dropped", d, exp_reg[2]);

      // R11: stop inside a data byte
      m_start();
      m_send(8'hD2, a);
      m_send(8'h83, a);
      m_bit_out(1'b0); m_bit_out(1'b0); m_bit_out(1'b0);
      m_stop();
      chk("R11 stop releases", sda_oe, 0);
      rd_byte(5'd3, d); chk("R11 stop drops byte", d, exp_reg[3]);

      check_block("R3 final");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule